// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the system clock into the timing strobes a serial port needs. A 24-bit increment, loaded by a host one byte at a time, is added every clock into a free-running 24-bit phase accumulator. Each time the accumulator's top bit goes from 0 to 1, the block emits a one-clock oversample tick. The average tick rate is therefore the clock frequency times the increment divided by 2^24. Because the accumulator carries its fractional remainder from one wrap to the next, the long-run rate is exact even when the clock is not an integer multiple of the baud rate.

Two divide-by-eight phase counters turn the ticks into bit-period enables, so one serial bit lasts eight ticks. The transmit counter runs freely from reset. The receive counter can be cleared by a resynchronize pulse, which a receiver raises when it detects a start-bit edge so that its bit grid lines up with the incoming frame. To reach a baud rate B from a clock F, program the increment to B * 2^27 / F.

Top module: `baud_tick_gen`

## Requirements
- R1: The increment register is written in bytes. `incr_we[0]` loads `incr_wdata` into bits 23:16, `incr_we[1]` into bits 15:8 and `incr_we[2]` into bits 7:0. Every enabled lane loads at the same clock edge. From the next cycle on, `incr_rdata` shows the full 24-bit value with the same bit layout.
- R2: On every clock the accumulator adds the increment held before that edge, modulo 2^24. It is never cleared by a tick. A new increment affects only the additions made after it is written.
- R3: `os_tick` is high for exactly one cycle. It goes high one clock after the accumulator's bit 23 changes from 0 to 1, so the tick count over a window is the number of such rises.
- R4: `os_tick` is never high in two consecutive cycles. With an increment of 0x800000 it fires every second cycle.
- R5: `rx_bit_en` is a one-cycle pulse. It rises one clock after every eighth tick counted since reset or since the last resynchronize pulse.
- R6: `tx_bit_en` is a one-cycle pulse. It rises one clock after every eighth tick counted since reset, and `rx_resync` has no effect on it.
- R7: `rx_resync` clears the receive phase count. `rx_bit_en` is low in the cycle after a resynchronize pulse, and a tick that coincides with the pulse is not counted.
- R8: Reset clears the increment, the accumulator and both phase counts, and drives all outputs low. While the increment is zero, no tick or bit enable occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| incr_we | input | 3 | Byte-lane write enables; lane 0 is the most significant byte |
| incr_wdata | input | 8 | Byte written to each enabled lane |
| rx_resync | input | 1 | Clears the receive phase count (start-bit alignment) |
| os_tick | output | 1 | Oversample tick, one clock wide |
| rx_bit_en | output | 1 | Receive bit-period enable |
| tx_bit_en | output | 1 | Transmit bit-period enable |
| incr_rdata | output | 24 | Readback of the increment register |

## Verification
Checks made on every cycle cover these rules: a lane write shows up in its own field one cycle later, a tick never lasts more than one cycle, a tick follows a rise of the accumulator's top bit, the accumulator stays still while the increment is zero, every bit enable follows a tick, and a resynchronize pulse silences the receive enable. Other properties can only be shown by the bench's scenarios, because they depend on long sequences. These include the exact tick spacing for whole and fractional increments, the carry-over of the accumulator across an increment change, the separation of the transmit and receive phases under repeated and tick-coincident resynchronize pulses, and recovery from a reset in mid-run.

// File: rtl/baud_pkg.sv
package baud_pkg;
   // True when v is a positive power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Top bit index of a byte lane, with lane 0 being the most significant.
   function automatic int lane_hi(input int acc_w, input int byte_w, input int lane);
      return acc_w - 1 - lane * byte_w;
   endfunction
endpackage

// File: rtl/baud_incr_reg.sv
module baud_incr_reg
   import baud_pkg::*;
#(
   parameter int ACC_W  = 24,
   parameter int BYTE_W = 8,
   localparam int NB    = ACC_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NB-1:0]     wr_en,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [ACC_W-1:0]  incr
);
   for (genvar g = 0; g < NB; g++) begin : g_lane
      localparam int HI = lane_hi(ACC_W, BYTE_W, g);
      logic [BYTE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (rst)
            lane_q <= '0;
         else if (wr_en[g])
            lane_q <= wr_data;
      end

      assign incr[HI -: BYTE_W] = lane_q;

      AST_LANE_LOAD: assert property (@(posedge clk) disable iff (rst)
         wr_en[g] |=> (incr[HI -: BYTE_W] == $past(wr_data))) else $error("lane load"); // R1
   end
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc #(
   parameter int ACC_W = 24,
   localparam int MSB  = ACC_W - 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] incr,
   output logic             tick
);
   logic [ACC_W-1:0] acc_q;
   logic             msb_q;
   logic             tick_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         msb_q  <= 1'b0;
         tick_q <= 1'b0;
      end else begin
         acc_q  <= acc_q + incr;
         msb_q  <= acc_q[MSB];
         tick_q <= acc_q[MSB] & ~msb_q;
      end
   end

   assign tick = tick_q;

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick) else $error("tick wider than one cycle"); // R4

   AST_TICK_FROM_RISE: assert property (@(posedge clk) disable iff (rst)
      tick |-> ($past(acc_q[MSB]) && !$past(acc_q[MSB], 2))) else $error("tick without rise"); // R3

   AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (incr == '0) |=> $stable(acc_q)) else $error("accumulator moved with zero increment"); // R8
endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div
   import baud_pkg::*;
#(
   parameter int OVS  = 8,
   localparam int PH_W = (OVS > 1) ? $clog2(OVS) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic resync,
   output logic bit_en
);
   logic [PH_W-1:0] ph_q;
   logic [PH_W-1:0] ph_nx;
   logic            last;
   logic            en_q;

   assign last = (ph_q == PH_W'(OVS - 1));

   if (is_pow2(OVS)) begin : g_wrap
      assign ph_nx = ph_q + 1'b1;
   end else begin : g_cmp
      assign ph_nx = last ? '0 : ph_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst || resync) begin
         ph_q <= '0;
         en_q <= 1'b0;
      end else if (tick) begin
         ph_q <= ph_nx;
         en_q <= last;
      end else begin
         en_q <= 1'b0;
      end
   end

   assign bit_en = en_q;

   AST_EN_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
      bit_en |-> $past(tick)) else $error("bit enable without tick"); // R5

   AST_RESYNC_MUTES: assert property (@(posedge clk) disable iff (rst)
      resync |=> !bit_en) else $error("bit enable after resync"); // R7
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
   parameter int ACC_W  = 24,
   parameter int BYTE_W = 8,
   parameter int OVS    = 8,
   localparam int NB    = ACC_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [NB-1:0]     incr_we,
   input  logic [BYTE_W-1:0] incr_wdata,
   input  logic              rx_resync,
   output logic              os_tick,
   output logic              rx_bit_en,
   output logic              tx_bit_en,
   output logic [ACC_W-1:0]  incr_rdata
);
   if (ACC_W % BYTE_W != 0) begin : g_bad_width
      $error("ACC_W must be a whole number of bytes");
   end
   if (OVS < 2) begin : g_bad_ovs
      $error("OVS must be at least 2");
   end

   logic [ACC_W-1:0] incr;
   logic             tick;

   baud_incr_reg #(.ACC_W(ACC_W), .BYTE_W(BYTE_W)) u_incr (
      .clk(clk), .rst(rst), .wr_en(incr_we), .wr_data(incr_wdata), .incr(incr)
   );

   baud_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .incr(incr), .tick(tick)
   );

   baud_bit_div #(.OVS(OVS)) u_rx_div (
      .clk(clk), .rst(rst), .tick(tick), .resync(rx_resync), .bit_en(rx_bit_en)
   );

   baud_bit_div #(.OVS(OVS)) u_tx_div (
      .clk(clk), .rst(rst), .tick(tick), .resync(1'b0), .bit_en(tx_bit_en)
   );

   assign os_tick    = tick;
   assign incr_rdata = incr;

   AST_TX_IGNORES_RESYNC: assert property (@(posedge clk) disable iff (rst)
      tx_bit_en |-> $past(tick)) else $error("tx enable without tick"); // R6
endmodule

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  incr_we = '0;
   logic [7:0]  incr_wdata = '0;
   logic        rx_resync = 1'b0;
   logic        os_tick, rx_bit_en, tx_bit_en;
   logic [23:0] incr_rdata;

   int vectors = 0, miscompares = 0;
   int n_tick = 0, n_rx = 0, n_tx = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   baud_tick_gen u_baud_tick_gen (
      .clk(clk), .rst(rst), .incr_we(incr_we), .incr_wdata(incr_wdata),
      .rx_resync(rx_resync), .os_tick(os_tick), .rx_bit_en(rx_bit_en),
      .tx_bit_en(tx_bit_en), .incr_rdata(incr_rdata)
   );

   // Behavioural reference model, advanced at each rising edge.
   int unsigned m_inc, m_acc;
   bit m_prev, m_tick, m_rx, m_tx;
   int m_rph, m_tph;

   always @(posedge clk) begin
      if (rst) begin
         m_inc = 0; m_acc = 0; m_prev = 0; m_tick = 0;
         m_rx = 0; m_tx = 0; m_rph = 0; m_tph = 0;
      end else begin
         bit seen;
         seen   = m_tick;
         m_tick = m_acc[23] && !m_prev;
         m_prev = m_acc[23];
         m_acc  = (m_acc + m_inc) & 32'h00FF_FFFF;
         if (incr_we[0]) m_inc = (m_inc & 32'h0000_FFFF) | (int'(incr_wdata) << 16);
         if (incr_we[1]) m_inc = (m_inc & 32'h00FF_00FF) | (int'(incr_wdata) << 8);
         if (incr_we[2]) m_inc = (m_inc & 32'h00FF_FF00) | int'(incr_wdata);
         if (rx_resync) begin m_rph = 0; m_rx = 0; end
         else if (seen) begin m_rx = (m_rph == 7); m_rph = (m_rph + 1) % 8; end
         else m_rx = 0;
         if (seen) begin m_tx = (m_tph == 7); m_tph = (m_tph + 1) % 8; end
         else m_tx = 0;
      end
   end

   task automatic report(input string req, input longint got, input longint exp);
      miscompares++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
   endtask

   // Cycle-by-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (!rst && !done) begin
         vectors++;
         if (incr_rdata !== m_inc[23:0]) report("R1 readback", incr_rdata, m_inc);
         if (os_tick !== m_tick) report("R2/R3 tick", os_tick, m_tick);
         if (rx_bit_en !== m_rx) report("R5/R7 rx_bit_en", rx_bit_en, m_rx);
         if (tx_bit_en !== m_tx) report("R6 tx_bit_en", tx_bit_en, m_tx);
         n_tick += int'(os_tick); n_rx += int'(rx_bit_en); n_tx += int'(tx_bit_en);
      end
   end

   task automatic check(input bit ok, input string req, input longint got, input longint exp);
      vectors++;
      if (!ok) report(req, got, exp);
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wr(input logic [2:0] we, input logic [7:0] d);
      incr_we = we; incr_wdata = d;
      step(1);
      incr_we = '0;
   endtask

   task automatic clear_counts();
      n_tick = 0; n_rx = 0; n_tx = 0;
   endtask

   initial begin
      step(3);
      // R8: reset state
      check(os_tick === 1'b0 && rx_bit_en === 1'b0 && tx_bit_en === 1'b0, "R8 outputs in reset",
            {os_tick, rx_bit_en, tx_bit_en}, 0);
      rst = 1'b0;
      step(1);
      check(incr_rdata === 24'h0, "R8 increment after reset", incr_rdata, 0);
      clear_counts();
      step(60);
      check(n_tick == 0 && n_rx == 0 && n_tx == 0, "R8 no ticks at zero increment", n_tick, 0);

      // R1: byte lanes, upper lane first
      wr(3'b001, 8'h20);
      step(1);
      check(incr_rdata === 24'h200000, "R1 lane 0 to bits 23:16", incr_rdata, 24'h200000);
      clear_counts();
      step(800);
      check(n_tick == 100, "R3 ticks at 1/8 increment", n_tick, 100);
      check(n_rx >= 12 && n_rx <= 13, "R5 rx bit enables", n_rx, 12);
      check(n_tx >= 12 && n_tx <= 13, "R6 tx bit enables", n_tx, 12);

      // R1: lower lanes, then simultaneous lanes
      wr(3'b100, 8'h35);
      wr(3'b010, 8'h7C);
      step(1);
      check(incr_rdata === 24'h207C35, "R1 lanes 1 and 2", incr_rdata, 24'h207C35);
      step(100);
      wr(3'b111, 8'h0A);
      step(1);
      check(incr_rdata === 24'h0A0A0A, "R1 simultaneous lanes", incr_rdata, 24'h0A0A0A);

      // R2: fractional rate, accumulator carries across wraps
      clear_counts();
      step(2000);
      begin
         longint exp;
         exp = (64'd2000 * 64'h0A0A0A) >> 24;
         check(n_tick >= exp - 1 && n_tick <= exp + 1, "R2 fractional tick count", n_tick, exp);
      end

      // R4: maximum rate
      wr(3'b111, 8'h00);
      wr(3'b001, 8'h80);
      step(4);
      clear_counts();
      step(200);
      check(n_tick == 100, "R4 tick every second cycle", n_tick, 100);

      // R7: resync held on every cycle silences rx only; R6 tx keeps running
      clear_counts();
      rx_resync = 1'b1;
      step(100);
      rx_resync = 1'b0;
      step(1);
      check(n_rx == 0, "R7 rx silent under resync", n_rx, 0);
      check(n_tx >= 6, "R6 tx unaffected by resync", n_tx, 6);

      // R7: isolated resync pulses at several phases
      for (int k = 0; k < 12; k++) begin
         rx_resync = 1'b1;
         step(1);
         rx_resync = 1'b0;
         step(5 + 3 * k);
      end
      wr(3'b001, 8'hC0);
      step(150);
      rx_resync = 1'b1; step(1); rx_resync = 1'b0;
      check(rx_bit_en === 1'b0, "R7 rx low after resync", rx_bit_en, 0);
      step(200);

      // R8: reset in mid-run
      rst = 1'b1;
      step(2);
      check(incr_rdata === 24'h0 && os_tick === 1'b0, "R8 mid-run reset", incr_rdata, 0);
      rst = 1'b0;
      wr(3'b010, 8'hFF);
      step(300);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog expired got=0 expected=1");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule